// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block keeps three eight-bit registers: pending requests, lines in service and masked lines. Each clock it decides whether a new interrupt should be signalled to the processor side, and which line wins. Request lines can be sampled on a rising edge or by level, either for all lines or line by line. A rotation base sets which line currently has the highest priority. Acknowledge cycles and end-of-interrupt commands arrive as strobes from the surrounding bus logic. They update the in-service register and the rotation base.

The outputs are registered. Each cycle the block finds the highest-priority pending, unmasked line. It asserts the interrupt only when that line sits strictly above every line still being served. Two options change which in-service lines count in that comparison. Special mask drops in-service lines that are masked. Cascade-master nesting drops the line that carries the cascaded controller. The register access decoding and any second controller sit outside this block.

Top module: `rot_prio_resolver`

## Requirements
- R1: Priority position p belongs to line (p + prio_base) mod 8, and position 0 is the highest. A set with no bits has position 8 ("none").
- R2: The candidate is the pending line (request bit set, mask bit clear) with the lowest position. Whenever int_req is high, win_line names that line, and its request bit is set and its mask bit clear. When int_req is low, win_line is 0. A mask_wr strobe loads mask_data into the mask register.
- R3: int_req is high only when the candidate's position is strictly lower than the lowest position among the in-service lines that count. A request on a line that is already in service does not raise int_req.
- R4: With special_mask high, in-service lines whose mask bit is set are left out of the current-priority search.
- R5: With nested_master high, the in-service bit of cascade line 2 is left out of the current-priority search.
- R6: For an edge-mode line, the request bit is set when the input is 1 and was 0 in the previous cycle. The bit then holds after the input falls, until an acknowledge clears it.
- R7: A line is in level mode when level_all is high or when its bit in line_level is set. In level mode the request bit equals the input sampled at the previous edge, and an acknowledge does not clear it.
- R8: An acknowledge (ack_stb with ack_line) while auto_eoi is low sets that line's in-service bit. In edge mode it also clears the line's request bit.
- R9: An acknowledge while auto_eoi is high leaves the in-service register unchanged. If rot_on_aeoi is also high, prio_base becomes ack_line + 1 (mod 8).
- R10: Command code 1 (non-specific EOI) clears the in-service bit with the lowest position. Code 2 does the same and also sets prio_base to that line + 1. With nothing in service, neither code changes anything.
- R11: Code 3 (specific EOI) clears the in-service bit of cmd_line. Code 4 does the same and also sets prio_base to cmd_line + 1.
- R12: Code 5 sets prio_base to cmd_line + 1 and leaves the in-service register alone. Codes 0, 6 and 7 change nothing.
- R13: Synchronous reset clears the request, in-service, mask and previous-level registers, prio_base, int_req and win_line.
- R14: Outputs are registered. A change on any input at clock edge k shows on every output right after edge k, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines |
| level_all | input | 1 | Puts every line in level mode |
| line_level | input | 8 | Per-line level mode select |
| auto_eoi | input | 1 | Acknowledge does not mark a line in service |
| rot_on_aeoi | input | 1 | Rotate the base on an auto-EOI acknowledge |
| special_mask | input | 1 | Masked in-service lines drop out of the current priority |
| nested_master | input | 1 | In-service bit of the cascade line drops out of the current priority |
| mask_wr | input | 1 | Load the mask register |
| mask_data | input | 8 | New mask value |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_line | input | 3 | Line being acknowledged |
| cmd_stb | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (1..5, others no effect) |
| cmd_line | input | 3 | Line or priority operand of the command |
| int_req | output | 1 | Interrupt request to the processor side |
| win_line | output | 3 | Winning line |
| req_q | output | 8 | Request register |
| svc_q | output | 8 | In-service register |
| mask_q | output | 8 | Mask register |
| prio_base | output | 3 | Line at priority position 0 |

## Verification
The checker assumes that an acknowledge and a command never share a cycle. Its acknowledge and set-priority properties hold back when they do. It also reads the configuration flags one cycle late, so it assumes those flags change only between whole operations. The directed stimulus issues one strobe per cycle. The random phase picks an acknowledge or a command in a cycle, never both. It changes the mode flags only at block boundaries, so every property keeps within its assumptions while the in-service and rotation state still drifts freely.

// File: rtl/rpr_pkg.sv
`timescale 1ns/1ps
package rpr_pkg;
  typedef enum logic [2:0] {
    CMD_NOP        = 3'd0,
    CMD_EOI_NS     = 3'd1,
    CMD_EOI_NS_ROT = 3'd2,
    CMD_EOI_SP     = 3'd3,
    CMD_EOI_SP_ROT = 3'd4,
    CMD_SET_PRIO   = 3'd5
  } rpr_cmd_e;
endpackage

// File: rtl/rpr_prio_find.sv
`timescale 1ns/1ps
// Rotated priority search: returns the lowest position p whose line
// (p + base) mod N has its bit set, or N when the vector is empty.
module rpr_prio_find #(
  parameter int N = 8,
  localparam int IW = $clog2(N),
  localparam int PW = IW + 1
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] base,
  output logic [PW-1:0] pos
);
  logic [N-1:0] rot;

  for (genvar p = 0; p < N; p++) begin : g_rot
    assign rot[p] = vec[IW'(p) + base];
  end

  always_comb begin
    pos = PW'(N);
    for (int p = N - 1; p >= 0; p--) begin
      if (rot[p]) pos = PW'(p);
    end
  end
endmodule

// File: rtl/rpr_req_capture.sv
`timescale 1ns/1ps
// Next value of the request register, per line edge or level capture.
module rpr_req_capture #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  irq_in,
  input  logic [N-1:0]  lvl,
  input  logic [N-1:0]  prev_q,
  input  logic [N-1:0]  req_q,
  input  logic          ack_stb,
  input  logic [IW-1:0] ack_line,
  output logic [N-1:0]  req_n
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic hit;
    logic rise;
    assign hit  = ack_stb && (ack_line == IW'(i));
    assign rise = irq_in[i] && !prev_q[i];
    assign req_n[i] = lvl[i] ? irq_in[i] : ((req_q[i] && !hit) || rise);
  end
endmodule

// File: rtl/rpr_svc_ctrl.sv
`timescale 1ns/1ps
// Next in-service register and rotation base from acknowledge and commands.
module rpr_svc_ctrl
  import rpr_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = $clog2(N),
  localparam int PW = IW + 1
) (
  input  logic [N-1:0]  svc_q,
  input  logic [IW-1:0] base_q,
  input  logic          auto_eoi,
  input  logic          rot_on_aeoi,
  input  logic          ack_stb,
  input  logic [IW-1:0] ack_line,
  input  logic          cmd_stb,
  input  logic [2:0]    cmd_op,
  input  logic [IW-1:0] cmd_line,
  output logic [N-1:0]  svc_n,
  output logic [IW-1:0] base_n
);
  logic [PW-1:0] hi_pos;
  logic [IW-1:0] hi_line;
  logic          hi_any;
  logic [N-1:0]  clr;
  logic [N-1:0]  set;
  logic          cmd_rot;
  logic [IW-1:0] cmd_base;

  rpr_prio_find #(.N(N)) u_hi (
    .vec  (svc_q),
    .base (base_q),
    .pos  (hi_pos)
  );

  assign hi_any  = (hi_pos != PW'(N));
  assign hi_line = hi_pos[IW-1:0] + base_q;

  always_comb begin
    clr      = '0;
    cmd_rot  = 1'b0;
    cmd_base = base_q;
    if (cmd_stb) begin
      unique case (rpr_cmd_e'(cmd_op))
        CMD_EOI_NS: begin
          if (hi_any) clr[hi_line] = 1'b1;
        end
        CMD_EOI_NS_ROT: begin
          if (hi_any) begin
            clr[hi_line] = 1'b1;
            cmd_rot      = 1'b1;
            cmd_base     = hi_line + IW'(1);
          end
        end
        CMD_EOI_SP: clr[cmd_line] = 1'b1;
        CMD_EOI_SP_ROT: begin
          clr[cmd_line] = 1'b1;
          cmd_rot       = 1'b1;
          cmd_base      = cmd_line + IW'(1);
        end
        CMD_SET_PRIO: begin
          cmd_rot  = 1'b1;
          cmd_base = cmd_line + IW'(1);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    set = '0;
    if (ack_stb && !auto_eoi) set[ack_line] = 1'b1;
  end

  always_comb begin
    if (cmd_rot)
      base_n = cmd_base;
    else if (ack_stb && auto_eoi && rot_on_aeoi)
      base_n = ack_line + IW'(1);
    else
      base_n = base_q;
  end

  assign svc_n = (svc_q & ~clr) | set;
endmodule

// File: rtl/rpr_resolve.sv
`timescale 1ns/1ps
// Decides the interrupt output from a register state snapshot.
module rpr_resolve #(
  parameter int N = 8,
  parameter int CASC_LINE = 2,
  localparam int IW = $clog2(N),
  localparam int PW = IW + 1
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  svc,
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] base,
  input  logic          special_mask,
  input  logic          nested_master,
  output logic          fire,
  output logic [IW-1:0] line
);
  logic [N-1:0]  pend;
  logic [N-1:0]  cur_set;
  logic [PW-1:0] cand_pos;
  logic [PW-1:0] cur_pos;

  assign pend = req & ~mask;

  always_comb begin
    cur_set = svc;
    if (special_mask)  cur_set = cur_set & ~mask;
    if (nested_master) cur_set[CASC_LINE] = 1'b0;
  end

  rpr_prio_find #(.N(N)) u_cand (
    .vec  (pend),
    .base (base),
    .pos  (cand_pos)
  );

  rpr_prio_find #(.N(N)) u_cur (
    .vec  (cur_set),
    .base (base),
    .pos  (cur_pos)
  );

  assign fire = (cand_pos < cur_pos);
  assign line = fire ? (cand_pos[IW-1:0] + base) : '0;
endmodule

// File: rtl/rot_prio_resolver.sv
`timescale 1ns/1ps
module rot_prio_resolver
  import rpr_pkg::*;
#(
  parameter int N = 8,
  parameter int CASC_LINE = 2,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic          level_all,
  input  logic [N-1:0]  line_level,
  input  logic          auto_eoi,
  input  logic          rot_on_aeoi,
  input  logic          special_mask,
  input  logic          nested_master,
  input  logic          mask_wr,
  input  logic [N-1:0]  mask_data,
  input  logic          ack_stb,
  input  logic [IW-1:0] ack_line,
  input  logic          cmd_stb,
  input  logic [2:0]    cmd_op,
  input  logic [IW-1:0] cmd_line,
  output logic          int_req,
  output logic [IW-1:0] win_line,
  output logic [N-1:0]  req_q,
  output logic [N-1:0]  svc_q,
  output logic [N-1:0]  mask_q,
  output logic [IW-1:0] prio_base
);
  logic [N-1:0]  prev_q;
  logic [N-1:0]  lvl;
  logic [N-1:0]  req_n;
  logic [N-1:0]  svc_n;
  logic [N-1:0]  mask_n;
  logic [IW-1:0] base_n;
  logic          fire_n;
  logic [IW-1:0] line_n;

  assign lvl    = {N{level_all}} | line_level;
  assign mask_n = mask_wr ? mask_data : mask_q;

  rpr_req_capture #(.N(N)) u_cap (
    .irq_in   (irq_in),
    .lvl      (lvl),
    .prev_q   (prev_q),
    .req_q    (req_q),
    .ack_stb  (ack_stb),
    .ack_line (ack_line),
    .req_n    (req_n)
  );

  rpr_svc_ctrl #(.N(N)) u_svc (
    .svc_q       (svc_q),
    .base_q      (prio_base),
    .auto_eoi    (auto_eoi),
    .rot_on_aeoi (rot_on_aeoi),
    .ack_stb     (ack_stb),
    .ack_line    (ack_line),
    .cmd_stb     (cmd_stb),
    .cmd_op      (cmd_op),
    .cmd_line    (cmd_line),
    .svc_n       (svc_n),
    .base_n      (base_n)
  );

  // Resolve on the next state so the registered outputs line up with it.
  rpr_resolve #(.N(N), .CASC_LINE(CASC_LINE)) u_res (
    .req           (req_n),
    .svc           (svc_n),
    .mask          (mask_n),
    .base          (base_n),
    .special_mask  (special_mask),
    .nested_master (nested_master),
    .fire          (fire_n),
    .line          (line_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      req_q     <= '0;
      svc_q     <= '0;
      mask_q    <= '0;
      prio_base <= '0;
      int_req   <= 1'b0;
      win_line  <= '0;
    end else begin
      prev_q    <= irq_in;
      req_q     <= req_n;
      svc_q     <= svc_n;
      mask_q    <= mask_n;
      prio_base <= base_n;
      int_req   <= fire_n;
      win_line  <= line_n;
    end
  end
endmodule

// File: rtl/rpr_checker.sv
`timescale 1ns/1ps
module rpr_checker #(
  parameter int N = 8,
  parameter int CASC_LINE = 2,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  irq_in,
  input logic          level_all,
  input logic [N-1:0]  line_level,
  input logic          auto_eoi,
  input logic          nested_master,
  input logic          ack_stb,
  input logic [IW-1:0] ack_line,
  input logic          cmd_stb,
  input logic [2:0]    cmd_op,
  input logic [IW-1:0] cmd_line,
  input logic          int_req,
  input logic [IW-1:0] win_line,
  input logic [N-1:0]  req_q,
  input logic [N-1:0]  svc_q,
  input logic [N-1:0]  mask_q,
  input logic [IW-1:0] prio_base
);
  logic [N-1:0] lvl_c;
  assign lvl_c = {N{level_all}} | line_level;

  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (rst)
    int_req |-> (req_q[win_line] && !mask_q[win_line])); // R2

  AST_WIN_ABOVE_SVC: assert property (@(posedge clk) disable iff (rst)
    (int_req && !($past(nested_master) && win_line == IW'(CASC_LINE)))
      |-> !svc_q[win_line]); // R3

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((req_q ^ $past(irq_in)) & $past(lvl_c)) == '0)); // R7

  AST_ACK_MARKS_SVC: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && !auto_eoi && !cmd_stb) |=> svc_q[$past(ack_line)]); // R8

  AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && !lvl_c[ack_line] && !irq_in[ack_line])
      |=> !req_q[$past(ack_line)]); // R8

  AST_AEOI_NO_SVC: assert property (@(posedge clk) disable iff (rst)
    (ack_stb && auto_eoi && !cmd_stb) |=> (svc_q == $past(svc_q))); // R9

  AST_SETPRIO_BASE: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd_op == 3'd5) |=> (prio_base == IW'($past(cmd_line) + 1'b1))); // R12

  AST_SETPRIO_KEEPS_SVC: assert property (@(posedge clk) disable iff (rst)
    (cmd_stb && cmd_op == 3'd5 && !ack_stb) |=> (svc_q == $past(svc_q))); // R12

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!int_req && svc_q == '0 && req_q == '0 && prio_base == '0)); // R13
endmodule

bind rot_prio_resolver rpr_checker #(.N(N), .CASC_LINE(CASC_LINE)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .irq_in        (irq_in),
  .level_all     (level_all),
  .line_level    (line_level),
  .auto_eoi      (auto_eoi),
  .nested_master (nested_master),
  .ack_stb       (ack_stb),
  .ack_line      (ack_line),
  .cmd_stb       (cmd_stb),
  .cmd_op        (cmd_op),
  .cmd_line      (cmd_line),
  .int_req       (int_req),
  .win_line      (win_line),
  .req_q         (req_q),
  .svc_q         (svc_q),
  .mask_q        (mask_q),
  .prio_base     (prio_base)
);

// File: tb/sim_rot_prio_resolver.sv
`timescale 1ns/1ps
module sim_rot_prio_resolver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0, line_level = '0, mask_data = '0;
  logic       level_all = 0, auto_eoi = 0, rot_on_aeoi = 0;
  logic       special_mask = 0, nested_master = 0, mask_wr = 0;
  logic       ack_stb = 0, cmd_stb = 0;
  logic [2:0] ack_line = '0, cmd_op = '0, cmd_line = '0;
  logic       int_req;
  logic [2:0] win_line, prio_base;
  logic [7:0] req_q, svc_q, mask_q;

  int tests = 0, fails = 0;
  bit done = 0;

  // bench reference state
  logic [7:0] m_req = '0, m_svc = '0, m_msk = '0, m_prev = '0;
  int         m_base = 0, e_int = 0, e_win = 0;

  always #10 clk = ~clk;

  rot_prio_resolver u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .level_all(level_all),
    .line_level(line_level), .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi),
    .special_mask(special_mask), .nested_master(nested_master),
    .mask_wr(mask_wr), .mask_data(mask_data), .ack_stb(ack_stb),
    .ack_line(ack_line), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .cmd_line(cmd_line), .int_req(int_req), .win_line(win_line),
    .req_q(req_q), .svc_q(svc_q), .mask_q(mask_q), .prio_base(prio_base)
  );

  // lowest position p with bit (p+base)%8 set; 8 if none (R1)
  function automatic int pos_of(logic [7:0] v, int base);
    for (int p = 0; p < 8; p++) if (v[(p + base) % 8]) return p;
    return 8;
  endfunction

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] lv, nreq, nsvc;
    int nbase, hp, cand, cur;
    logic [7:0] cm;
    if (rst) begin
      m_req = 0; m_svc = 0; m_msk = 0; m_prev = 0; m_base = 0;
      e_int = 0; e_win = 0;
      return;
    end
    lv = {8{level_all}} | line_level;
    nreq = m_req; nsvc = m_svc; nbase = m_base;
    for (int i = 0; i < 8; i++) begin
      if (lv[i]) nreq[i] = irq_in[i];
      else begin
        if (ack_stb && ack_line == i) nreq[i] = 0;
        if (irq_in[i] && !m_prev[i]) nreq[i] = 1;
      end
    end
    if (ack_stb && auto_eoi && rot_on_aeoi) nbase = (ack_line + 1) % 8;
    if (cmd_stb) begin
      hp = pos_of(m_svc, m_base);
      case (cmd_op)
        3'd1: if (hp < 8) nsvc[(hp + m_base) % 8] = 0;
        3'd2: if (hp < 8) begin
                nsvc[(hp + m_base) % 8] = 0; nbase = (hp + m_base + 1) % 8;
              end
        3'd3: nsvc[cmd_line] = 0;
        3'd4: begin nsvc[cmd_line] = 0; nbase = (cmd_line + 1) % 8; end
        3'd5: nbase = (cmd_line + 1) % 8;
        default: ;
      endcase
    end
    if (ack_stb && !auto_eoi) nsvc[ack_line] = 1;
    if (mask_wr) m_msk = mask_data;
    m_req = nreq; m_svc = nsvc; m_base = nbase; m_prev = irq_in;
    cand = pos_of(m_req & ~m_msk, m_base);
    cm = m_svc;
    if (special_mask) cm = cm & ~m_msk;
    if (nested_master) cm[2] = 0;
    cur = pos_of(cm, m_base);
    e_int = (cand < cur) ? 1 : 0;
    e_win = e_int ? (cand + m_base) % 8 : 0;
  endtask

  // one cycle: update reference, let the edge pass, compare at the falling edge (R14)
  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " int_req"},  int_req,   e_int);
    chk({tag, " win_line"}, win_line,  e_win);
    chk({tag, " req"},      req_q,     m_req);
    chk({tag, " svc"},      svc_q,     m_svc);
    chk({tag, " mask"},     mask_q,    m_msk);
    chk({tag, " base"},     prio_base, m_base);
    ack_stb = 0; cmd_stb = 0; mask_wr = 0;
  endtask

  task automatic do_ack(int l);  ack_stb = 1; ack_line = 3'(l); endtask
  task automatic do_cmd(int op, int l); cmd_stb = 1; cmd_op = 3'(op); cmd_line = 3'(l); endtask
  task automatic do_mask(logic [7:0] m); mask_wr = 1; mask_data = m; endtask

  initial begin
    @(negedge clk);
    rst = 1; irq_in = 8'hFF;
    tick("R13"); tick("R13");
    chk("R13 int after reset", int_req, 0);
    rst = 0; irq_in = 0;
    tick("R13");

    irq_in = 8'h08; tick("R6");
    chk("R6 edge sets", req_q, 8'h08); chk("R2 win", win_line, 3); chk("R2 int", int_req, 1);
    irq_in = 0; tick("R6");
    chk("R6 held", req_q, 8'h08);
    do_mask(8'h08); tick("R2");
    chk("R2 masked", int_req, 0);
    irq_in = 8'h20; tick("R2");
    chk("R2 other line", win_line, 5);
    irq_in = 0; do_mask(8'h00); tick("R1");
    chk("R1 lowest pos", win_line, 3);
    do_cmd(5, 4); tick("R12");
    chk("R12 base", prio_base, 5); chk("R1 rotated win", win_line, 5);
    do_cmd(5, 7); tick("R12");
    chk("R1 back", win_line, 3);
    do_ack(3); tick("R8");
    chk("R8 svc", svc_q, 8'h08); chk("R8 edge clr", req_q, 8'h20); chk("R3 lower blocked", int_req, 0);
    do_cmd(1, 0); tick("R10");
    chk("R10 eoi", svc_q, 0); chk("R10 win", win_line, 5);
    do_ack(5); tick("R8");
    irq_in = 8'h40; tick("R3");
    chk("R3 below svc", int_req, 0);
    irq_in = 0; do_mask(8'h20); special_mask = 1; tick("R4");
    chk("R4 special", int_req, 1); chk("R4 win", win_line, 6);
    special_mask = 0; tick("R4");
    chk("R4 off", int_req, 0);
    do_cmd(3, 5); tick("R11");
    chk("R11 sp eoi", svc_q, 0); chk("R11 win", win_line, 6);
    do_mask(0); tick("R2");
    do_ack(6); tick("R8");
    irq_in = 8'h04; tick("R3");
    do_ack(2); tick("R8");
    chk("R8 svc two", svc_q, 8'h44);
    irq_in = 0; tick("R6");
    irq_in = 8'h04; tick("R3");
    chk("R3 strict same line", int_req, 0);
    nested_master = 1; tick("R5");
    chk("R5 nested", int_req, 1); chk("R5 win", win_line, 2);
    nested_master = 0; irq_in = 0;
    do_cmd(2, 0); tick("R10");
    chk("R10 rot base", prio_base, 3); chk("R10 rot svc", svc_q, 8'h40);
    do_cmd(4, 6); tick("R11");
    chk("R11 rot base", prio_base, 7); chk("R11 win", win_line, 2);
    do_cmd(6, 1); tick("R12");
    chk("R12 nop code", prio_base, 7);
    do_ack(2); tick("R8");
    do_cmd(1, 0); tick("R10");
    line_level = 8'h02; irq_in = 8'h02; tick("R7");
    chk("R7 level", req_q, 8'h02);
    do_ack(1); tick("R7");
    chk("R7 ack keeps", req_q, 8'h02);
    irq_in = 0; tick("R7");
    chk("R7 follows low", req_q, 8'h00);
    do_cmd(1, 0); tick("R10");
    level_all = 1; irq_in = 8'h81; tick("R7");
    level_all = 0; line_level = 0; irq_in = 0;
    auto_eoi = 1; rot_on_aeoi = 1;
    do_ack(0); tick("R9");
    chk("R9 no svc", svc_q, 0); chk("R9 base", prio_base, 1);
    rot_on_aeoi = 0; do_ack(7); tick("R9");
    chk("R9 base kept", prio_base, 1);
    auto_eoi = 0;

    // random sweep, one strobe per cycle, modes change per block
    for (int blk = 0; blk < 24; blk++) begin
      level_all    = ($urandom % 4 == 0);
      line_level   = 8'($urandom);
      auto_eoi     = ($urandom % 3 == 0);
      rot_on_aeoi  = ($urandom % 2 == 0);
      special_mask = ($urandom % 3 == 0);
      nested_master = ($urandom % 3 == 0);
      for (int c = 0; c < 200; c++) begin
        int r;
        irq_in = 8'($urandom & $urandom);
        r = $urandom % 10;
        if (r < 4) do_ack(int_req ? int'(win_line) : int'($urandom % 8));
        else if (r < 6) do_cmd($urandom % 8, $urandom % 8);
        else if (r == 6) do_mask(8'($urandom & $urandom));
        tick("R2");
      end
    end
    rst = 1; tick("R13"); rst = 0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule